// File: doc/BRIEF.md
# Decode-Stage Branch Target Verifier

This block sits in the decode stage. It examines each group of up to `LANES` instructions that decode passes on toward rename. For every instruction that is both direct and unconditional, decode already knows the real target, so the block compares it with the next PC that fetch predicted. When the two differ, the block trims the forwarded group. It then emits a one-cycle redirect record that tells fetch where to restart and which sequence number marks the youngest surviving instruction. Every instruction younger than that boundary is to be discarded downstream.

Groups enter through a valid/ready handshake and leave through a one-deep output register with its own valid/ready handshake. `in_ready` is high whenever the output register is empty, or is being drained in the same cycle. A group that is not accepted must be held unchanged by the sender. An output group stays stable until `out_ready` is seen high. The lanes of a group are packed from lane 0, so `in_valid` implies `in_lane_vld[0]`. Sequence numbers rise with the lane index. A plain `ds_mode` pin selects delay-slot behaviour, in which an ordinary mispredicted branch keeps the instruction behind it and the squash waits one instruction. The redirect, the resolution counters and the sticky error flag are plain outputs.

Top module: `bvfy_branch_verify`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A group accepted at a clock edge appears on the output lanes (`out_keep`, `out_pc`, `out_seq`) after that edge. While `out_valid` is high and `out_ready` is low, the output lanes hold their values.
- R2: A forwarded lane is checked when class bit 1 (direct) and class bit 2 (unconditional) are both set. `resolved_cnt` grows by the number of checked lanes in each accepted group. `mispred_cnt` grows by one when a checked lane's target differs from its predicted next PC. Both counters reset to 0.
- R3: With `ds_mode` low, the oldest mismatching lane and all older valid lanes are forwarded, and younger lanes are dropped (`out_keep` bit 0). A redirect is pulsed on `redir_valid` for one cycle, in the same cycle that the group appears on the output, with `redir_kill_seq` equal to the branch's own sequence number.
- R4: Every redirect carries the branch sequence number in `redir_seq`. It carries the branch target in `redir_npc` and the target plus 4 in `redir_nnpc`. `redir_taken` is 1 when the predicted next PC differs from the branch PC plus 4.
- R5: With `ds_mode` high, a mismatching branch that was predicted taken and has class bit 3 (conditional delay slot) set behaves as in R3.
- R6: With `ds_mode` high, any other mismatching branch also forwards the next valid lane (its delay slot) unchecked, and drops the lanes after it. The redirect is pulsed for that group with `redir_kill_seq` equal to the branch sequence number plus 1.
- R7: In the case of R6 where the branch is the last valid lane of its group, the redirect is held pending. The next accepted group forwards only lane 0, unchecked, and its acceptance produces the held redirect.
- R8: At most one redirect is produced per accepted group, and it is taken from the oldest mismatching checked lane. No redirect is produced when every checked lane matches.
- R9: A forwarded lane that is predicted taken while class bit 0 (control) is clear sets `fatal_err`, which stays set until reset.
- R10: `out_issue_rdy[i]` is 1 for a forwarded lane whose source-register count is zero, and 0 otherwise.
- R11: `redir_unblock` equals the value of `thr_stalled` in the acceptance cycle that produces the redirect.
- R12: After reset, `out_valid`, `redir_valid` and `fatal_err` are 0, both counters are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ds_mode | input | 1 | Delay-slot behaviour select |
| thr_stalled | input | 1 | Thread is currently blocked or unblocking |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Input group accepted when high with in_valid |
| in_lane_vld | input | LANES | Per-lane valid, packed from lane 0 |
| in_pc | input | LANES*PC_W | Per-lane instruction PC |
| in_pred_taken | input | LANES | Per-lane predicted-taken bit |
| in_pred_npc | input | LANES*PC_W | Per-lane predicted next PC |
| in_cls | input | LANES*4 | Per-lane class: bit0 control, bit1 direct, bit2 unconditional, bit3 conditional delay slot |
| in_target | input | LANES*PC_W | Per-lane computed branch target |
| in_seq | input | LANES*SEQ_W | Per-lane sequence number |
| in_nsrc | input | LANES*NSRC_W | Per-lane source-register count |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Downstream takes the output group |
| out_keep | output | LANES | Lanes forwarded (1) or dropped (0) |
| out_issue_rdy | output | LANES | Forwarded lane has no source registers |
| out_pc | output | LANES*PC_W | Lane PCs of the output group |
| out_seq | output | LANES*SEQ_W | Lane sequence numbers of the output group |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_seq | output | SEQ_W | Sequence number of the mispredicted branch |
| redir_kill_seq | output | SEQ_W | Youngest surviving sequence number |
| redir_npc | output | PC_W | Restart PC (branch target) |
| redir_nnpc | output | PC_W | Restart PC plus 4 |
| redir_taken | output | 1 | Branch was predicted off the fall-through path |
| redir_unblock | output | 1 | Fetch must also be released from a stall |
| resolved_cnt | output | CNT_W | Number of branches checked |
| mispred_cnt | output | CNT_W | Number of target mismatches |
| fatal_err | output | 1 | Sticky non-control predicted-taken error |

## Verification
Two functions can fall in the same accepted group. The first is the release of a delay-slot redirect held from the previous group. The second is a fresh mismatch inside the new group. The bench provokes this by ending a group with a deferred mismatch and following it with a group that holds its own mismatching branch. It then judges that only lane 0 is forwarded, that the held record (kill boundary = held branch plus 1) is emitted, and that the new branch is neither counted nor redirected. Output back-pressure and redirect timing also meet: groups are accepted after random stall periods, and the redirect pulse must coincide with the group's first output cycle and be absent while the group is held.

// File: rtl/bvfy_pkg.sv
package bvfy_pkg;
  localparam int CLS_W      = 4;
  localparam int CLS_CTRL   = 0;
  localparam int CLS_DIRECT = 1;
  localparam int CLS_UNCOND = 2;
  localparam int CLS_DSCOND = 3;
  localparam int INSN_BYTES = 4;

  typedef struct packed {
    logic chk;       // direct unconditional: decode can prove target
    logic mism;      // checked and target differs from prediction
    logic immed;     // squash at the branch itself (no delay slot kept)
    logic taken;     // prediction left the fall-through path
    logic fatal;     // predicted taken but not a control instruction
    logic issue_rdy; // no source registers
  } lane_flags_t;
endpackage

// File: rtl/bvfy_lane_check.sv
module bvfy_lane_check
  import bvfy_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int NSRC_W = 3
) (
  input  logic              ds_mode,
  input  logic [PC_W-1:0]   pc,
  input  logic              pred_taken,
  input  logic [PC_W-1:0]   pred_npc,
  input  logic [CLS_W-1:0]  cls,
  input  logic [PC_W-1:0]   target,
  input  logic [NSRC_W-1:0] nsrc,
  output lane_flags_t       flags
);
  logic is_chk;

  assign is_chk          = cls[CLS_DIRECT] & cls[CLS_UNCOND];
  assign flags.chk       = is_chk;
  assign flags.mism      = is_chk & (target != pred_npc);
  assign flags.immed     = !ds_mode || (pred_taken && cls[CLS_DSCOND]);
  assign flags.taken     = (pred_npc != (pc + PC_W'(INSN_BYTES)));
  assign flags.fatal     = pred_taken & ~cls[CLS_CTRL];
  assign flags.issue_rdy = (nsrc == '0);
endmodule

// File: rtl/bvfy_select.sv
module bvfy_select #(
  parameter int LANES = 4,
  parameter int IDX_W = 2,
  parameter int CHK_W = 3
) (
  input  logic [LANES-1:0] lane_vld,
  input  logic [LANES-1:0] chk_v,
  input  logic [LANES-1:0] mism_v,
  input  logic [LANES-1:0] immed_v,
  input  logic             pend,
  output logic [LANES-1:0] keep,
  output logic             fire,
  output logic [IDX_W-1:0] br_idx,
  output logic             plus1,
  output logic             set_pend,
  output logic [CHK_W-1:0] n_chk,
  output logic             mis_hit
);
  logic stop;
  logic ds_next;

  always_comb begin
    keep     = '0;
    fire     = 1'b0;
    br_idx   = '0;
    plus1    = 1'b0;
    n_chk    = '0;
    mis_hit  = 1'b0;
    stop     = 1'b0;
    ds_next  = 1'b0;
    if (pend) begin
      // held delay-slot redirect: lane 0 is the delay slot, nothing else passes
      keep[0] = lane_vld[0];
      fire    = lane_vld[0];
      stop    = 1'b1;
    end
    for (int i = 0; i < LANES; i++) begin
      if (lane_vld[i] && !stop) begin
        keep[i] = 1'b1;
        if (ds_next) begin
          fire    = 1'b1;
          ds_next = 1'b0;
          stop    = 1'b1;
        end else if (chk_v[i]) begin
          n_chk = n_chk + 1'b1;
          if (mism_v[i]) begin
            mis_hit = 1'b1;
            br_idx  = IDX_W'(i);
            if (immed_v[i]) begin
              fire = 1'b1;
              stop = 1'b1;
            end else begin
              plus1   = 1'b1;
              ds_next = 1'b1;
            end
          end
        end
      end
    end
    set_pend = ds_next;
  end
endmodule

// File: rtl/bvfy_branch_verify.sv
module bvfy_branch_verify
  import bvfy_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PC_W   = 32,
  parameter int SEQ_W  = 16,
  parameter int NSRC_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ds_mode,
  input  logic                    thr_stalled,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        in_lane_vld,
  input  logic [LANES*PC_W-1:0]   in_pc,
  input  logic [LANES-1:0]        in_pred_taken,
  input  logic [LANES*PC_W-1:0]   in_pred_npc,
  input  logic [LANES*CLS_W-1:0]  in_cls,
  input  logic [LANES*PC_W-1:0]   in_target,
  input  logic [LANES*SEQ_W-1:0]  in_seq,
  input  logic [LANES*NSRC_W-1:0] in_nsrc,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES-1:0]        out_keep,
  output logic [LANES-1:0]        out_issue_rdy,
  output logic [LANES*PC_W-1:0]   out_pc,
  output logic [LANES*SEQ_W-1:0]  out_seq,
  output logic                    redir_valid,
  output logic [SEQ_W-1:0]        redir_seq,
  output logic [SEQ_W-1:0]        redir_kill_seq,
  output logic [PC_W-1:0]         redir_npc,
  output logic [PC_W-1:0]         redir_nnpc,
  output logic                    redir_taken,
  output logic                    redir_unblock,
  output logic [CNT_W-1:0]        resolved_cnt,
  output logic [CNT_W-1:0]        mispred_cnt,
  output logic                    fatal_err
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CHK_W = $clog2(LANES + 1);

  lane_flags_t      flg [LANES];
  logic [LANES-1:0] chk_v, mism_v, immed_v, rdy_v, fatal_v;
  logic [LANES-1:0] keep;
  logic             fire, plus1, set_pend, mis_hit, acc, fatal_any;
  logic [IDX_W-1:0] br_idx;
  logic [CHK_W-1:0] n_chk;
  logic [SEQ_W-1:0] br_seq;
  logic [PC_W-1:0]  br_tgt;
  logic             br_taken;

  // held delay-slot redirect
  logic             pend_vld;
  logic [SEQ_W-1:0] pend_seq;
  logic [PC_W-1:0]  pend_tgt;
  logic             pend_taken;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      bvfy_lane_check #(.PC_W(PC_W), .NSRC_W(NSRC_W)) u_lane (
        .ds_mode    (ds_mode),
        .pc         (in_pc[g*PC_W +: PC_W]),
        .pred_taken (in_pred_taken[g]),
        .pred_npc   (in_pred_npc[g*PC_W +: PC_W]),
        .cls        (in_cls[g*CLS_W +: CLS_W]),
        .target     (in_target[g*PC_W +: PC_W]),
        .nsrc       (in_nsrc[g*NSRC_W +: NSRC_W]),
        .flags      (flg[g])
      );
      assign chk_v[g]   = flg[g].chk;
      assign mism_v[g]  = flg[g].mism;
      assign immed_v[g] = flg[g].immed;
      assign rdy_v[g]   = flg[g].issue_rdy;
      assign fatal_v[g] = flg[g].fatal;
    end
  endgenerate

  bvfy_select #(.LANES(LANES), .IDX_W(IDX_W), .CHK_W(CHK_W)) u_sel (
    .lane_vld (in_lane_vld & {LANES{in_valid}}),
    .chk_v    (chk_v),
    .mism_v   (mism_v),
    .immed_v  (immed_v),
    .pend     (pend_vld),
    .keep     (keep),
    .fire     (fire),
    .br_idx   (br_idx),
    .plus1    (plus1),
    .set_pend (set_pend),
    .n_chk    (n_chk),
    .mis_hit  (mis_hit)
  );

  assign in_ready  = !out_valid || out_ready;
  assign acc       = in_valid && in_ready;
  assign br_seq    = in_seq[br_idx*SEQ_W +: SEQ_W];
  assign br_tgt    = in_target[br_idx*PC_W +: PC_W];
  assign br_taken  = flg[br_idx].taken;
  assign fatal_any = |(keep & fatal_v);

  // output group register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_keep      <= '0;
      out_issue_rdy <= '0;
      out_pc        <= '0;
      out_seq       <= '0;
    end else if (acc) begin
      out_valid     <= 1'b1;
      out_keep      <= keep;
      out_issue_rdy <= keep & rdy_v;
      out_pc        <= in_pc;
      out_seq       <= in_seq;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  // redirect record, pending slot, counters, error flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid    <= 1'b0;
      redir_seq      <= '0;
      redir_kill_seq <= '0;
      redir_npc      <= '0;
      redir_nnpc     <= '0;
      redir_taken    <= 1'b0;
      redir_unblock  <= 1'b0;
      pend_vld       <= 1'b0;
      pend_seq       <= '0;
      pend_tgt       <= '0;
      pend_taken     <= 1'b0;
      resolved_cnt   <= '0;
      mispred_cnt    <= '0;
      fatal_err      <= 1'b0;
    end else begin
      redir_valid <= acc && fire;
      if (acc) begin
        resolved_cnt <= resolved_cnt + CNT_W'(n_chk);
        mispred_cnt  <= mispred_cnt + CNT_W'(mis_hit);
        fatal_err    <= fatal_err | fatal_any;
        if (fire) begin
          redir_unblock <= thr_stalled;
          if (pend_vld) begin
            redir_seq      <= pend_seq;
            redir_kill_seq <= pend_seq + 1'b1;
            redir_npc      <= pend_tgt;
            redir_nnpc     <= pend_tgt + PC_W'(INSN_BYTES);
            redir_taken    <= pend_taken;
          end else begin
            redir_seq      <= br_seq;
            redir_kill_seq <= br_seq + SEQ_W'(plus1);
            redir_npc      <= br_tgt;
            redir_nnpc     <= br_tgt + PC_W'(INSN_BYTES);
            redir_taken    <= br_taken;
          end
        end
        if (pend_vld && fire) pend_vld <= 1'b0;
        if (set_pend) begin
          pend_vld   <= 1'b1;
          pend_seq   <= br_seq;
          pend_tgt   <= br_tgt;
          pend_taken <= br_taken;
        end
      end
    end
  end
endmodule

// File: rtl/bvfy_checker.sv
module bvfy_checker #(
  parameter int LANES = 4,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [LANES-1:0]      out_keep,
  input logic [LANES*PC_W-1:0] out_pc,
  input logic                  redir_valid,
  input logic [SEQ_W-1:0]      redir_seq,
  input logic [SEQ_W-1:0]      redir_kill_seq,
  input logic [PC_W-1:0]       redir_npc,
  input logic [PC_W-1:0]       redir_nnpc,
  input logic [CNT_W-1:0]      resolved_cnt,
  input logic [CNT_W-1:0]      mispred_cnt,
  input logic                  fatal_err
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_keep) && $stable(out_pc)); // R1
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid); // R1
  AST_MIS_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mispred_cnt) |-> !$stable(resolved_cnt)); // R2
  AST_REDIR_WITH_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> out_valid && (out_keep != '0)); // R3
  AST_NEXT_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> redir_nnpc == redir_npc + PC_W'(4)); // R4
  AST_KILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_kill_seq == redir_seq) ||
                    (redir_kill_seq == redir_seq + SEQ_W'(1))); // R6
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> fatal_err); // R9
endmodule

bind bvfy_branch_verify bvfy_checker #(
  .LANES(LANES), .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_bvfy_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_keep       (out_keep),
  .out_pc         (out_pc),
  .redir_valid    (redir_valid),
  .redir_seq      (redir_seq),
  .redir_kill_seq (redir_kill_seq),
  .redir_npc      (redir_npc),
  .redir_nnpc     (redir_nnpc),
  .resolved_cnt   (resolved_cnt),
  .mispred_cnt    (mispred_cnt),
  .fatal_err      (fatal_err)
);

// File: tb/test_bvfy_branch_verify.sv
`timescale 1ns/1ps
module test_bvfy_branch_verify;
  localparam int W = 4, PW = 32, SW = 16, NW = 3, CW = 16;

  logic clk = 0, rst_n = 0;
  logic ds_mode = 0, thr_stalled = 0, in_valid = 0, out_ready = 0;
  logic in_ready, out_valid, redir_valid, redir_taken, redir_unblock, fatal_err;
  logic [W-1:0] in_lane_vld = '0, in_pred_taken = '0, out_keep, out_issue_rdy;
  logic [W*PW-1:0] in_pc = '0, in_pred_npc = '0, in_target = '0, out_pc;
  logic [W*4-1:0]  in_cls = '0;
  logic [W*SW-1:0] in_seq = '0, out_seq;
  logic [W*NW-1:0] in_nsrc = '0;
  logic [SW-1:0] redir_seq, redir_kill_seq;
  logic [PW-1:0] redir_npc, redir_nnpc;
  logic [CW-1:0] resolved_cnt, mispred_cnt;

  bvfy_branch_verify #(.LANES(W), .PC_W(PW), .SEQ_W(SW), .NSRC_W(NW), .CNT_W(CW))
  i_bvfy_branch_verify (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // lane stimulus
  logic          b_vld [W];
  logic [PW-1:0] b_pc [W], b_pnpc [W], b_tgt [W];
  logic          b_ptk [W];
  logic [3:0]    b_cls [W];
  logic [NW-1:0] b_ns [W];
  logic [SW-1:0] b_seq [W];
  logic [SW-1:0] gseq = 16'h0100;

  // model state
  bit            m_pend = 0, m_fatal = 0;
  logic [SW-1:0] p_seq;
  logic [PW-1:0] p_tgt;
  bit            p_taken;
  logic [CW-1:0] m_res = 0, m_mis = 0;
  logic [W-1:0]  e_keep, e_issue;
  bit            e_fire, e_taken, e_unb;
  logic [SW-1:0] e_seq, e_kill;
  logic [PW-1:0] e_npc;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] du(input bit ctrl, input bit dscond);
    return {dscond, 1'b1, 1'b1, ctrl}; // bit2 uncond, bit1 direct
  endfunction

  task automatic clear_lanes();
    for (int i = 0; i < W; i++) begin
      b_vld[i] = 0; b_pc[i] = 32'h1000 + 32'(i*4); b_pnpc[i] = b_pc[i] + 4;
      b_tgt[i] = b_pnpc[i]; b_ptk[i] = 0; b_cls[i] = 4'h0; b_ns[i] = 3'd1;
    end
  endtask

  task automatic model();
    bit stop = 0, dsn = 0;
    e_keep = '0; e_fire = 0;
    if (m_pend) begin
      e_keep[0] = 1; e_fire = 1; e_seq = p_seq; e_kill = p_seq + 1;
      e_npc = p_tgt; e_taken = p_taken; m_pend = 0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (b_vld[i] && !stop) begin
          e_keep[i] = 1;
          if (dsn) begin e_fire = 1; stop = 1; dsn = 0; end
          else if (b_cls[i][1] && b_cls[i][2]) begin
            m_res++;
            if (b_tgt[i] != b_pnpc[i]) begin
              m_mis++; e_seq = b_seq[i]; e_npc = b_tgt[i];
              e_taken = (b_pnpc[i] != b_pc[i] + 4);
              if (!ds_mode || (b_ptk[i] && b_cls[i][3])) begin
                e_kill = b_seq[i]; e_fire = 1; stop = 1;
              end else begin
                e_kill = b_seq[i] + 1; dsn = 1;
              end
            end
          end
        end
      end
      if (dsn) begin m_pend = 1; p_seq = e_seq; p_tgt = e_npc; p_taken = e_taken; end
    end
    e_issue = '0;
    for (int i = 0; i < W; i++) begin
      if (e_keep[i] && b_ns[i] == 0) e_issue[i] = 1;
      if (e_keep[i] && b_ptk[i] && !b_cls[i][0]) m_fatal = 1;
    end
    e_unb = thr_stalled;
  endtask

  task automatic send(input string tag);
    int hold;
    logic [W-1:0] pk;
    @(negedge clk);
    for (int i = 0; i < W; i++) begin
      b_seq[i] = gseq + SW'(i);
      in_lane_vld[i] = b_vld[i]; in_pred_taken[i] = b_ptk[i];
      in_pc[i*PW +: PW] = b_pc[i]; in_pred_npc[i*PW +: PW] = b_pnpc[i];
      in_target[i*PW +: PW] = b_tgt[i]; in_cls[i*4 +: 4] = b_cls[i];
      in_seq[i*SW +: SW] = b_seq[i]; in_nsrc[i*NW +: NW] = b_ns[i];
    end
    gseq = gseq + SW'(W);
    in_valid = 1; out_ready = 0;
    hold = out_valid ? int'($urandom_range(0, 2)) : 0;
    pk = out_keep;
    repeat (hold) begin
      chk(!in_ready, "R1 ready low while full", longint'(in_ready), 0);
      @(negedge clk);
      chk(out_valid && out_keep == pk, "R1 group held", longint'(out_keep), longint'(pk));
      chk(!redir_valid, "R8 no redirect while held", longint'(redir_valid), 0);
    end
    out_ready = 1;
    model();
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    chk(out_valid, {tag, " R1 out_valid"}, longint'(out_valid), 1);
    chk(out_pc == in_pc && out_seq == in_seq, "R1 lane data", longint'(out_pc[31:0]), longint'(in_pc[31:0]));
    chk(out_keep == e_keep, {tag, " keep"}, longint'(out_keep), longint'(e_keep));
    chk(out_issue_rdy == e_issue, "R10 issue ready", longint'(out_issue_rdy), longint'(e_issue));
    chk(redir_valid == e_fire, {tag, " R8 redirect"}, longint'(redir_valid), longint'(e_fire));
    if (e_fire && redir_valid) begin
      chk(redir_seq == e_seq, "R4 seq", longint'(redir_seq), longint'(e_seq));
      chk(redir_kill_seq == e_kill, {tag, " kill seq"}, longint'(redir_kill_seq), longint'(e_kill));
      chk(redir_npc == e_npc && redir_nnpc == e_npc + 4, "R4 npc", longint'(redir_nnpc), longint'(e_npc + 4));
      chk(redir_taken == e_taken, "R4 taken", longint'(redir_taken), longint'(e_taken));
      chk(redir_unblock == e_unb, "R11 unblock", longint'(redir_unblock), longint'(e_unb));
    end
    chk(resolved_cnt == m_res, "R2 resolved", longint'(resolved_cnt), longint'(m_res));
    chk(mispred_cnt == m_mis, "R2 mispred", longint'(mispred_cnt), longint'(m_mis));
    chk(fatal_err == m_fatal, "R9 fatal", longint'(fatal_err), longint'(m_fatal));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_lanes();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R12 reset state
    chk(!out_valid && !redir_valid && !fatal_err, "R12 idle outputs", longint'(out_valid), 0);
    chk(resolved_cnt == 0 && mispred_cnt == 0, "R12 counters", longint'(resolved_cnt), 0);
    chk(in_ready, "R12 ready", longint'(in_ready), 1);

    // R3: mismatch on lane 1, lanes 2..3 dropped
    clear_lanes();
    for (int i = 0; i < W; i++) b_vld[i] = 1;
    b_cls[1] = du(1, 0); b_tgt[1] = 32'h8000; b_ns[0] = 0;
    send("R3");
    // R8: two mismatches, oldest wins; R11 with stall
    clear_lanes(); thr_stalled = 1;
    for (int i = 0; i < W; i++) b_vld[i] = 1;
    b_cls[2] = du(1, 0); b_tgt[2] = 32'h9000; b_pnpc[2] = 32'h2000;
    b_cls[3] = du(1, 0); b_tgt[3] = 32'hA000;
    send("R8");
    thr_stalled = 0;
    // R2: matching branches only
    clear_lanes();
    for (int i = 0; i < 3; i++) begin b_vld[i] = 1; b_cls[i] = du(1, 0); end
    send("R2");
    // R5: delay-slot mode, predicted taken with conditional delay slot
    ds_mode = 1; clear_lanes();
    for (int i = 0; i < W; i++) b_vld[i] = 1;
    b_cls[0] = du(1, 1); b_ptk[0] = 1; b_pnpc[0] = 32'h3000; b_tgt[0] = 32'h3100;
    send("R5");
    // R6: delay slot kept, boundary plus one
    clear_lanes();
    for (int i = 0; i < W; i++) b_vld[i] = 1;
    b_cls[1] = du(1, 0); b_tgt[1] = 32'h4400;
    send("R6");
    // R7: branch on last lane, then a group with its own mismatch
    clear_lanes();
    for (int i = 0; i < W; i++) b_vld[i] = 1;
    b_cls[3] = du(1, 0); b_tgt[3] = 32'h5500; b_ptk[3] = 1; b_pnpc[3] = 32'h5000;
    send("R7 defer");
    clear_lanes(); thr_stalled = 1;
    for (int i = 0; i < W; i++) b_vld[i] = 1;
    b_cls[0] = du(1, 0); b_tgt[0] = 32'h6600; b_cls[1] = du(1, 0); b_tgt[1] = 32'h6700;
    send("R7 release");
    thr_stalled = 0; ds_mode = 0;

    // constrained random groups
    for (int g = 0; g < 400; g++) begin
      int n;
      clear_lanes();
      ds_mode = 1'($urandom_range(0, 1));
      thr_stalled = 1'($urandom_range(0, 1));
      n = int'($urandom_range(1, W));
      for (int i = 0; i < n; i++) begin
        b_vld[i] = 1;
        b_pc[i] = {$urandom()} & 32'hFFFF_FFFC;
        b_cls[i] = 4'($urandom_range(0, 15));
        b_ptk[i] = b_cls[i][0] ? 1'($urandom_range(0, 1)) : 1'b0;
        b_pnpc[i] = $urandom_range(0, 1) ? b_pc[i] + 4 : {$urandom()} & 32'hFFFF_FFFC;
        b_tgt[i] = $urandom_range(0, 2) == 0 ? 32'h0007_0000 + 32'(g*16) : b_pnpc[i];
        b_ns[i] = 3'($urandom_range(0, 3));
      end
      send("R3/R6 random");
    end

    // R9: non-control lane predicted taken
    ds_mode = 0; clear_lanes();
    b_vld[0] = 1; b_vld[1] = 1; b_ptk[1] = 1; b_cls[1] = 4'h0;
    send("R9");
    clear_lanes(); b_vld[0] = 1;
    send("R9 sticky");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule